// File: doc/BRIEF.md
# Differential Cyclic Shift Network

This block sits between a message store and a row of check-node processing lanes in a layered quasi-cyclic LDPC decoder. Each cycle it accepts one block of 42 soft messages (5 bits each), together with the block column they belong to and the circulant shift of the parity-check entry being processed. It then presents the messages rotated so that each processing lane receives the variable it is connected to.

Rotated messages go back into the store in their rotated order, so no inverse shifter is needed. To make this work, the block remembers the shift last applied to each of the 16 block columns and rotates only by the difference between the requested shift and that remembered one, taken modulo 42. The remembered shift is then replaced by the requested one.

A clear pulse at the start of every codeword returns all remembered shifts to zero, which is the orientation in which channel values are loaded. The result is registered and appears one cycle after the request.

Top module: `diff_cyclic_shifter`

## Requirements
- R1: While reset is asserted and on the first cycle after it, out_valid is 0 and out_data is all zeros, and every column's stored shift is 0.
- R2: out_valid equals the in_valid of the previous cycle, a latency of exactly one cycle.
- R3: For a valid request, lane r of out_data (bits r*5+4 down to r*5) equals lane (r+d) mod 42 of in_data, where d = (in_shift - old) mod 42 and old is the stored shift of column in_col.
- R4: A valid request sets the stored shift of column in_col to in_shift and leaves the other 15 columns unchanged.
- R5: A clear pulse sets all stored shifts to 0. A valid request in the same cycle as clear uses old = 0 and then stores its own in_shift.
- R6: When in_shift is less than old, the difference wraps, so d = in_shift + 42 - old. No divider is used to compute it.
- R7: A cycle without in_valid leaves out_data unchanged and changes no stored shift.
- R8: in_shift of a valid request lies in 0 to 41; 0 denotes the identity circulant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| clear | input | 1 | Start of codeword: zero all stored shifts |
| in_valid | input | 1 | Request valid |
| in_col | input | 4 | Block column index |
| in_shift | input | 6 | Circulant shift of the current entry |
| in_data | input | 210 | 42 lanes of 5-bit messages, lane 0 in the low bits |
| out_valid | output | 1 | Rotated block valid |
| out_data | output | 210 | Rotated block |

## Verification
Every result of a request is due on the clock edge that follows it: the rotated block, the valid flag and the held data when no request arrives. A stored-shift update only becomes visible through the rotation amount of the next request to the same column. The bench drives one request at a falling edge, lets one rising edge pass, and compares both outputs with its model at the next falling edge. A column's memory is therefore observed as soon as that column is accessed again.

// File: rtl/dcs_pkg.sv
package dcs_pkg;
    localparam int unsigned DEF_LANES = 42;
    localparam int unsigned DEF_LW    = 5;
    localparam int unsigned DEF_COLS  = 16;
endpackage

// File: rtl/dcs_mod_sub.sv
module dcs_mod_sub #(
    parameter int unsigned LANES = dcs_pkg::DEF_LANES,
    parameter int unsigned SW    = $clog2(LANES)
) (
    input  logic [SW-1:0] a,
    input  logic [SW-1:0] b,
    output logic [SW-1:0] d
);
    localparam int unsigned EW = SW + 1;
    localparam logic [EW-1:0] MODV = EW'(LANES);

    logic [EW-1:0] ax, bx, wrap_sum;

    always_comb begin
        ax       = {1'b0, a};
        bx       = {1'b0, b};
        wrap_sum = ax + MODV - bx;
        if (ax >= bx) begin
            d = SW'(ax - bx);
        end else begin
            d = wrap_sum[SW-1:0];
        end
    end
endmodule

// File: rtl/dcs_barrel_rot.sv
module dcs_barrel_rot #(
    parameter int unsigned LANES = dcs_pkg::DEF_LANES,
    parameter int unsigned LW    = dcs_pkg::DEF_LW,
    parameter int unsigned SW    = $clog2(LANES),
    parameter int unsigned DW    = LANES * LW
) (
    input  logic [DW-1:0] din,
    input  logic [SW-1:0] amt,
    output logic [DW-1:0] dout
);
    logic [SW:0][DW-1:0] stg;

    assign stg[0] = din;

    for (genvar s = 0; s < SW; s++) begin : g_stage
        logic [DW-1:0] rotated;
        for (genvar r = 0; r < LANES; r++) begin : g_lane
            localparam int unsigned SRC = (r + (1 << s)) % LANES;
            assign rotated[r*LW +: LW] = stg[s][SRC*LW +: LW];
        end
        assign stg[s+1] = amt[s] ? rotated : stg[s];
    end

    assign dout = stg[SW];
endmodule

// File: rtl/dcs_shift_table.sv
module dcs_shift_table #(
    parameter int unsigned LANES = dcs_pkg::DEF_LANES,
    parameter int unsigned COLS  = dcs_pkg::DEF_COLS,
    parameter int unsigned SW    = $clog2(LANES),
    parameter int unsigned CW    = $clog2(COLS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          wr_en,
    input  logic [CW-1:0] col,
    input  logic [SW-1:0] new_shift,
    output logic [SW-1:0] old_shift
);
    typedef struct packed {
        logic [COLS-1:0][SW-1:0] sh;
    } tbl_s;

    tbl_s tbl_d, tbl_q;

    always_comb begin
        tbl_d = tbl_q;
        if (clear) begin
            old_shift = '0;
            tbl_d.sh  = '0;
        end else begin
            old_shift = tbl_q.sh[col];
        end
        if (wr_en) begin
            tbl_d.sh[col] = new_shift;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tbl_q <= '0;
        end else begin
            tbl_q <= tbl_d;
        end
    end
endmodule

// File: rtl/diff_cyclic_shifter.sv
module diff_cyclic_shifter #(
    parameter int unsigned LANES = dcs_pkg::DEF_LANES,
    parameter int unsigned LW    = dcs_pkg::DEF_LW,
    parameter int unsigned COLS  = dcs_pkg::DEF_COLS,
    parameter int unsigned SW    = $clog2(LANES),
    parameter int unsigned CW    = $clog2(COLS),
    parameter int unsigned DW    = LANES * LW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          in_valid,
    input  logic [CW-1:0] in_col,
    input  logic [SW-1:0] in_shift,
    input  logic [DW-1:0] in_data,
    output logic          out_valid,
    output logic [DW-1:0] out_data
);
    typedef struct packed {
        logic          vld;
        logic [DW-1:0] data;
    } out_s;

    out_s st_d, st_q;

    logic [SW-1:0] old_shift;
    logic [SW-1:0] delta;
    logic [DW-1:0] rot_data;

    dcs_shift_table #(.LANES(LANES), .COLS(COLS), .SW(SW), .CW(CW)) u_tbl (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (clear),
        .wr_en     (in_valid),
        .col       (in_col),
        .new_shift (in_shift),
        .old_shift (old_shift)
    );

    dcs_mod_sub #(.LANES(LANES), .SW(SW)) u_sub (
        .a (in_shift),
        .b (old_shift),
        .d (delta)
    );

    dcs_barrel_rot #(.LANES(LANES), .LW(LW), .SW(SW), .DW(DW)) u_rot (
        .din  (in_data),
        .amt  (delta),
        .dout (rot_data)
    );

    always_comb begin
        st_d     = st_q;
        st_d.vld = in_valid;
        if (in_valid) begin
            st_d.data = rot_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid = st_q.vld;
    assign out_data  = st_q.data;
endmodule

// File: rtl/dcs_checker.sv
module dcs_checker #(
    parameter int unsigned LANES = dcs_pkg::DEF_LANES,
    parameter int unsigned SW    = $clog2(LANES),
    parameter int unsigned DW    = LANES * dcs_pkg::DEF_LW
) (
    input logic          clk,
    input logic          rst_n,
    input logic          clear,
    input logic          in_valid,
    input logic [SW-1:0] in_shift,
    input logic [DW-1:0] in_data,
    input logic          out_valid,
    input logic [DW-1:0] out_data
);
    p_valid_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    p_idle_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    p_hold_data_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(out_data));

    p_clear_identity_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (clear && in_valid && in_shift == '0) |=> (out_data == $past(in_data)));

    p_shift_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |-> (int'(in_shift) < int'(LANES)));
endmodule

bind diff_cyclic_shifter dcs_checker #(.LANES(LANES), .SW(SW), .DW(DW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (clear),
    .in_valid  (in_valid),
    .in_shift  (in_shift),
    .in_data   (in_data),
    .out_valid (out_valid),
    .out_data  (out_data)
);

// File: tb/sim_diff_cyclic_shifter.sv
`timescale 1ns/1ps
module sim_diff_cyclic_shifter;
    localparam int LANES = 42;
    localparam int LW    = 5;
    localparam int COLS  = 16;
    localparam int DW    = LANES * LW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          clear = 1'b0;
    logic          in_valid = 1'b0;
    logic [3:0]    in_col = '0;
    logic [5:0]    in_shift = '0;
    logic [DW-1:0] in_data = '0;
    logic          out_valid;
    logic [DW-1:0] out_data;

    int checks = 0;
    int errors = 0;
    int tbl [COLS];
    logic          exp_valid;
    logic [DW-1:0] exp_data;

    always #2 clk = ~clk;

    diff_cyclic_shifter u0 (
        .clk(clk), .rst_n(rst_n), .clear(clear), .in_valid(in_valid),
        .in_col(in_col), .in_shift(in_shift), .in_data(in_data),
        .out_valid(out_valid), .out_data(out_data)
    );

    task automatic check(input string tag);
        checks++;
        if (out_valid !== exp_valid || out_data !== exp_data) begin
            errors++;
            $display("FAIL %s: actual valid=%0b data=%h expected valid=%0b data=%h",
                     tag, out_valid, out_data, exp_valid, exp_data);
        end
    endtask

    function automatic logic [DW-1:0] make_data(input int seed, input bit rnd);
        logic [DW-1:0] v;
        for (int i = 0; i < LANES; i++) begin
            v[i*LW +: LW] = rnd ? LW'($urandom) : LW'((i * 7 + seed) % 32);
        end
        return v;
    endfunction

    task automatic step(input bit v, input int col, input int sh,
                        input logic [DW-1:0] data, input bit clr, input string tag);
        int d;
        clear    = clr;
        in_valid = v;
        in_col   = 4'(col);
        in_shift = 6'(sh);
        in_data  = data;
        if (clr) begin
            for (int c = 0; c < COLS; c++) tbl[c] = 0;
        end
        exp_valid = v;
        if (v) begin
            d = ((sh - tbl[col]) % LANES + LANES) % LANES;
            for (int r = 0; r < LANES; r++) begin
                exp_data[r*LW +: LW] = data[((r + d) % LANES)*LW +: LW];
            end
            tbl[col] = sh;
        end
        @(negedge clk);
        check(tag);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int c = 0; c < COLS; c++) tbl[c] = 0;
        exp_valid = 1'b0;
        exp_data  = '0;
        repeat (3) @(negedge clk);
        check("R1 during reset");
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after reset");

        step(1, 0, 5,  make_data(1, 0), 0, "R1 R3 first access col0 shift5");
        step(1, 0, 5,  make_data(2, 0), 0, "R3 R4 same shift identity");
        step(1, 0, 2,  make_data(3, 0), 0, "R6 wrap 2-5");
        step(1, 3, 41, make_data(4, 0), 0, "R4 other column untouched");
        step(1, 0, 0,  make_data(5, 0), 0, "R6 R8 back to identity shift");
        step(0, 7, 9,  make_data(6, 0), 0, "R7 idle holds data");
        step(1, 7, 9,  make_data(7, 0), 0, "R7 idle did not write col7");
        step(0, 0, 0,  make_data(8, 0), 1, "R5 clear alone");
        step(1, 3, 7,  make_data(9, 0), 0, "R5 col3 zero after clear");
        step(1, 3, 10, make_data(10, 0), 1, "R5 clear with valid");
        step(1, 3, 10, make_data(11, 0), 0, "R5 stored shift after clear");
        step(1, 15, 1, make_data(12, 0), 0, "R3 single lane step");
        step(1, 15, 0, make_data(13, 0), 0, "R6 wrap to 41");

        for (int k = 0; k < 400; k++) begin
            step(($urandom % 4) != 0, int'($urandom % COLS), int'($urandom % LANES),
                 make_data(k, 1), ($urandom % 25) == 0, "R3 R4 R6 random");
        end

        in_valid = 1'b0;
        clear    = 1'b0;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule